// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external serial master read and write a small bank of byte-wide control registers inside a chip. The master drives a serial clock, an active-low select and a data line. The block answers on the same shared data line (three-wire wiring) or on a separate output line (four-wire wiring). All pins are brought into the block clock domain through a synchronizer chain. Serial clock edges are recovered by comparing successive synchronized samples, so the block clock must run several times faster than the serial clock.

A transaction opens with a 16-bit header. The header carries a direction flag, a byte count and a start register address. Data bytes follow, and the register address advances by one after each byte. Two bits of the block's own configuration register choose the wiring and the bit order. A change to these bits applies from the next selection onward. Every register value drives the `ctrl_o` bus for the rest of the chip.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset all registers read 0x00, neither data output is enabled, the wiring is three-wire and bit order is most significant bit first.
- R2: Each transaction starts at the first serial clock rise after select goes low. Its first 16 bits form a header: bit 15 is the direction (1 = read), bits 14:13 are the byte count minus one, and bits 12:0 are the start address. Data bits are handled only after all 16 header bits have arrived.
- R3: In a write, each complete data byte is stored at the current address, and the address then advances by one. A count field of 0, 1 or 2 writes 1, 2 or 3 bytes.
- R4: In a read, the register at the current address is returned, and the address then advances by one after each byte. In three-wire wiring `sdio_oe` is high only during the data phase of a read.
- R5: A count field of 3 means streaming. Bytes keep transferring, at rising addresses, until select goes high.
- R6: Input bits are sampled on the rising serial clock edge. Output bits change only after a falling serial clock edge.
- R7: When register 0 bit 7 is 1, read data leaves on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R8: When register 0 bit 6 is 1, the header and every data byte are shifted least significant bit first, in both directions.
- R9: Wiring and bit order are captured when select goes low. A write to register 0 changes neither of them until the next transaction.
- R10: Select going high ends the transaction at any point. Both output enables go low, and a partly received byte is discarded.
- R11: Writes to addresses at or above the register count have no effect, and such addresses read 0x00. Bits 5:0 of register 0 are reserved: they are not stored and read as 0.
- R12: Once a non-streaming transfer has moved its counted bytes, further serial clock cycles have no effect until select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low select from the master |
| sdio_i | input | 1 | Input side of the shared data pin |
| sdio_o | output | 1 | Output side of the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo_o | output | 1 | Dedicated serial data output |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| ctrl_o | output | NUM_REGS*8 | Register contents, register n in bits 8n+7:8n |

## Verification
The bench builds the block with NUM_REGS = 8 and two synchronizer stages. With only eight registers, a short streaming read runs past the last defined register into undefined addresses, and those addresses must return zero. It also makes every register cheap to compare against a model through `ctrl_o`. With the serial clock six block clocks per half period, the synchronizer and edge-detect latency fits inside each half period. A header sent in one bit order can then be followed by a configuration write that flips the order for the next transaction.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int unsigned HDR_BITS  = 16;
  localparam int unsigned ADDR_W    = 13;
  localparam int unsigned CNT_W     = 2;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BITCNT_W  = $clog2(HDR_BITS);

  localparam int unsigned HDR_RW_BIT = HDR_BITS - 1;
  localparam int unsigned HDR_CNT_LO = ADDR_W;
  localparam int unsigned HDR_CNT_HI = ADDR_W + CNT_W - 1;

  localparam int unsigned CFG_ADDR     = 0;
  localparam int unsigned CFG_FOUR_BIT = 7;
  localparam int unsigned CFG_LSB_BIT  = 6;
  localparam logic [BYTE_W-1:0] CFG_MASK = 8'hC0;

  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_CSN  = 1;
  localparam int unsigned PIN_SDI  = 2;
  localparam int unsigned PIN_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } phase_t;

  typedef struct packed {
    logic four_wire;
    logic lsb_first;
  } mode_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = pin_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign pin_s = chain_q[STAGES-1];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTE_W-1:0]        rd_data,
  output mode_t                    cfg_mode,
  output logic [NUM_REGS*BYTE_W-1:0] ctrl_o
);

  localparam int unsigned BANK_W = NUM_REGS * BYTE_W;
  localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;
  logic              wr_in_range;
  logic              bank_en;
  logic              rd_in_range;
  logic [IDX_W-1:0]  rd_idx;

  assign wr_in_range = (wr_addr < LIMIT);
  assign bank_en     = wr_en && wr_in_range;

  // one byte lane per register; the configuration lane keeps only its defined bits
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    localparam logic [BYTE_W-1:0] KEEP = (g == CFG_ADDR) ? CFG_MASK : {BYTE_W{1'b1}};
    logic hit;
    assign hit = (wr_addr == ADDR_W'(g));
    assign bank_d[g*BYTE_W +: BYTE_W] = hit ? (wr_data & KEEP)
                                            : bank_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_d;
    end
  end

  assign rd_in_range = (rd_addr < LIMIT);
  assign rd_idx      = rd_addr[IDX_W-1:0];

  always_comb begin
    rd_data = '0;
    if (rd_in_range) begin
      rd_data = bank_q[rd_idx*BYTE_W +: BYTE_W];
    end
  end

  assign cfg_mode.four_wire = bank_q[CFG_ADDR*BYTE_W + CFG_FOUR_BIT];
  assign cfg_mode.lsb_first = bank_q[CFG_ADDR*BYTE_W + CFG_LSB_BIT];
  assign ctrl_o = bank_q;

  // R11: a write outside the bank leaves every register untouched
  a_r11_undefined_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_in_range) |=> $stable(bank_q));

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  mode_t             cfg_mode,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              data_out,
  output logic              sdio_oe,
  output logic              sdo_oe
);

  localparam logic [BITCNT_W-1:0] HDR_LAST  = BITCNT_W'(HDR_BITS - 1);
  localparam logic [BITCNT_W-1:0] BYTE_LAST = BITCNT_W'(BYTE_W - 1);

  // edge recovery
  logic sclk_q, csn_q;
  logic sclk_rise, sclk_fall, cs_fall, cs_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_fall   = ~cs_n_s & csn_q;
  assign cs_high   = cs_n_s;

  // transaction state
  phase_t               state_q, state_d;
  mode_t                mode_q, mode_d;
  logic [HDR_BITS-1:0]  hdr_q, hdr_d, hdr_in;
  logic [BYTE_W-1:0]    byte_q, byte_d, byte_in;
  logic [BITCNT_W-1:0]  bits_q, bits_d;
  logic                 rd_q, rd_d;
  logic                 stream_q, stream_d;
  logic [CNT_W-1:0]     left_q, left_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [BYTE_W-1:0]    tx_q, tx_d;
  logic                 out_q, out_d;
  logic                 drive_q, drive_d;

  assign hdr_in  = mode_q.lsb_first ? {sdi_s, hdr_q[HDR_BITS-1:1]}
                                    : {hdr_q[HDR_BITS-2:0], sdi_s};
  assign byte_in = mode_q.lsb_first ? {sdi_s, byte_q[BYTE_W-1:1]}
                                    : {byte_q[BYTE_W-2:0], sdi_s};

  assign rd_addr = (state_q == ST_HDR) ? hdr_in[ADDR_W-1:0]
                                       : addr_q + ADDR_W'(1);

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    hdr_d    = hdr_q;
    byte_d   = byte_q;
    bits_d   = bits_q;
    rd_d     = rd_q;
    stream_d = stream_q;
    left_d   = left_q;
    addr_d   = addr_q;
    tx_d     = tx_q;
    out_d    = out_q;
    drive_d  = drive_q;
    wr_en    = 1'b0;

    if (cs_high) begin
      state_d = ST_IDLE;
      bits_d  = '0;
      drive_d = 1'b0;
    end else if (cs_fall) begin
      state_d = ST_HDR;
      mode_d  = cfg_mode;
      bits_d  = '0;
      drive_d = 1'b0;
    end else begin
      case (state_q)
        ST_HDR: begin
          if (sclk_rise) begin
            hdr_d  = hdr_in;
            bits_d = bits_q + BITCNT_W'(1);
            if (bits_q == HDR_LAST) begin
              rd_d     = hdr_in[HDR_RW_BIT];
              left_d   = hdr_in[HDR_CNT_HI:HDR_CNT_LO];
              stream_d = &hdr_in[HDR_CNT_HI:HDR_CNT_LO];
              addr_d   = hdr_in[ADDR_W-1:0];
              tx_d     = rd_data;
              bits_d   = '0;
              state_d  = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (sclk_rise) begin
            byte_d = byte_in;
            bits_d = bits_q + BITCNT_W'(1);
            if (bits_q == BYTE_LAST) begin
              bits_d = '0;
              wr_en  = ~rd_q;
              addr_d = addr_q + ADDR_W'(1);
              tx_d   = rd_data;
              if (!stream_q) begin
                if (left_q == '0) begin
                  state_d = ST_DONE;
                  drive_d = 1'b0;
                end else begin
                  left_d = left_q - CNT_W'(1);
                end
              end
            end
          end else if (sclk_fall && rd_q) begin
            out_d   = mode_q.lsb_first ? tx_q[0] : tx_q[BYTE_W-1];
            tx_d    = mode_q.lsb_first ? {1'b0, tx_q[BYTE_W-1:1]}
                                       : {tx_q[BYTE_W-2:0], 1'b0};
            drive_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      hdr_q    <= '0;
      byte_q   <= '0;
      bits_q   <= '0;
      rd_q     <= 1'b0;
      stream_q <= 1'b0;
      left_q   <= '0;
      addr_q   <= '0;
      tx_q     <= '0;
      out_q    <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      hdr_q    <= hdr_d;
      byte_q   <= byte_d;
      bits_q   <= bits_d;
      rd_q     <= rd_d;
      stream_q <= stream_d;
      left_q   <= left_d;
      addr_q   <= addr_d;
      tx_q     <= tx_d;
      out_q    <= out_d;
      drive_q  <= drive_d;
    end
  end

  assign wr_addr  = addr_q;
  assign wr_data  = byte_in;
  assign data_out = out_q;
  assign sdio_oe  = drive_q & ~mode_q.four_wire;
  assign sdo_oe   = drive_q &  mode_q.four_wire;

  // R2: the data phase is entered only after the sixteenth header bit
  a_r2_header_length: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) == ST_HDR) |-> ($past(bits_q) == HDR_LAST));

  // R6: the serial output bit moves only after a falling serial clock edge
  a_r6_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(out_q));

  // R10: deselect releases both output pins and parks the sequencer
  a_r10_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> (!sdio_oe && !sdo_oe && state_q == ST_IDLE));

  // R12: a finished counted transfer neither writes nor drives
  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> (!wr_en && !drive_q));

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe,
  output logic                       sdo_o,
  output logic                       sdo_oe,
  output logic [NUM_REGS*BYTE_W-1:0] ctrl_o
);

  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CSN;

  // reset: asserted at once, released in step with clk
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [PIN_W-1:0] pins_raw, pins_s;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = sclk;
    pins_raw[PIN_CSN]  = cs_n;
    pins_raw[PIN_SDI]  = sdio_i;
  end

  spi_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .pin_i (pins_raw),
    .pin_s (pins_s)
  );

  mode_t             cfg_mode;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              data_out;

  spi_xfer_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .sclk_s   (pins_s[PIN_SCLK]),
    .cs_n_s   (pins_s[PIN_CSN]),
    .sdi_s    (pins_s[PIN_SDI]),
    .cfg_mode (cfg_mode),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .data_out (data_out),
    .sdio_oe  (sdio_oe),
    .sdo_oe   (sdo_oe)
  );

  spi_reg_bank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_mode (cfg_mode),
    .ctrl_o   (ctrl_o)
  );

  assign sdio_o = data_out;
  assign sdo_o  = data_out;

  // R7: the two output pins are never enabled together
  a_r7_one_pin_driven: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(sdio_oe && sdo_oe));

endmodule

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 8;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk, cs_n, sdio_i;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [NREGS*8-1:0] ctrl_o;

  spi_cfg_slave #(.NUM_REGS(NREGS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .ctrl_o(ctrl_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0] model [NREGS];
  logic [7:0] tx_buf [8];

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  logic       mon_active = 1'b0;
  logic       mon_lsb = 1'b0;
  logic       mon_4w = 1'b0;
  logic [7:0] mon_byte;
  int         mon_cnt = 0;
  logic       mon_oe_ok;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung, expected done");
    finish_run();
  end

  // monitor: master samples read data on each rising serial clock
  initial begin
    forever begin
      @(posedge sclk);
      if (!mon_active) begin
        mon_cnt   = 0;
        mon_oe_ok = 1'b1;
      end else begin
        logic b;
        b = mon_4w ? sdo_o : sdio_o;
        if (mon_4w ? !(sdo_oe && !sdio_oe) : !(sdio_oe && !sdo_oe)) mon_oe_ok = 1'b0;
        mon_byte = mon_lsb ? {b, mon_byte[7:1]} : {mon_byte[6:0], b};
        mon_cnt++;
        if (mon_cnt == 8) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read byte: actual %h, expected none", mon_byte);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (mon_byte !== e.val || !mon_oe_ok) begin
              errors++;
              $display("FAIL %s: read byte actual %h (pin enables ok=%0d), expected %h (ok=1)",
                       e.tag, mon_byte, mon_oe_ok, e.val);
            end
          end
          mon_cnt   = 0;
          mon_oe_ok = 1'b1;
        end
      end
    end
  end

  function automatic logic [7:0] model_rd(int a);
    return (a < NREGS) ? model[a] : 8'h00;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdio_i = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits, input logic lsb);
    for (int k = 0; k < nbits; k++) begin
      send_bit(lsb ? w[k] : w[nbits-1-k]);
    end
  endtask

  // driver: one whole transaction; read expectations go to the scoreboard
  task automatic xfer(input logic rd, input int cnt, input int addr,
                      input int nbytes, input int extra_bits, input string tag);
    logic lsb, fw;
    logic [15:0] hdr;
    int limit;
    lsb = model[0][6];
    fw  = model[0][7];
    hdr = {rd, 2'(cnt), 13'(addr)};
    limit = (cnt == 3) ? nbytes : ((nbytes < cnt + 1) ? nbytes : cnt + 1);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_word(hdr, 16, lsb);
    if (rd) begin
      mon_lsb = lsb;
      mon_4w  = fw;
      for (int i = 0; i < limit; i++) exp_q.push_back('{model_rd(addr + i), tag});
      mon_active = 1'b1;
    end
    for (int i = 0; i < nbytes; i++) begin
      send_word({8'h00, rd ? 8'h00 : tx_buf[i]}, 8, lsb);
      if (!rd && i < limit && addr + i < NREGS)
        model[addr + i] = (addr + i == 0) ? (tx_buf[i] & 8'hC0) : tx_buf[i];
    end
    if (extra_bits > 0) send_word({8'h00, tx_buf[nbytes]}, extra_bits, lsb);
    repeat (HALF) @(negedge clk);
    mon_active = 1'b0;
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    logic [NREGS*8-1:0] exp_flat;
    for (int i = 0; i < NREGS; i++) exp_flat[i*8 +: 8] = model[i];
    checks++;
    if (ctrl_o !== exp_flat || sdio_oe !== 1'b0 || sdo_oe !== 1'b0) begin
      errors++;
      $display("FAIL %s: registers actual %h oe %b%b, expected %h oe 00",
               tag, ctrl_o, sdio_oe, sdo_oe, exp_flat);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b, expected %b", what, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    sclk = 1'b0;
    cs_n = 1'b1;
    sdio_i = 1'b0;
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check_regs("R1 reset state");

    tx_buf[0] = 8'hA5;
    xfer(1'b0, 0, 1, 1, 0, "R2 R3 single write");
    check_regs("R2 R3 single write");

    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
    xfer(1'b0, 2, 2, 3, 0, "R3 three byte write");
    check_regs("R3 three byte write");

    xfer(1'b1, 2, 1, 3, 0, "R4 R6 three byte read");
    check_regs("R4 released after read");

    tx_buf[0] = 8'h44; tx_buf[1] = 8'h55; tx_buf[2] = 8'h66; tx_buf[3] = 8'h77;
    xfer(1'b0, 3, 3, 4, 0, "R5 streaming write");
    check_regs("R5 streaming write");

    xfer(1'b1, 3, 5, 5, 0, "R5 R11 streaming read past bank end");

    tx_buf[0] = 8'h99; tx_buf[1] = 8'h88;
    xfer(1'b0, 0, 2, 2, 0, "R12 extra byte after count");
    check_regs("R12 extra byte after count");

    tx_buf[0] = 8'hEE;
    xfer(1'b0, 0, 13'h100, 1, 0, "R11 undefined address write");
    check_regs("R11 undefined address write");
    xfer(1'b1, 0, 13'h100, 1, 0, "R11 undefined address read");

    tx_buf[0] = 8'h3F;
    xfer(1'b0, 0, 0, 1, 0, "R11 reserved bits");
    check_regs("R11 reserved bits");
    xfer(1'b1, 0, 0, 1, 0, "R11 reserved bits read");

    tx_buf[0] = 8'h5C;
    xfer(1'b0, 0, 4, 0, 5, "R10 partial byte abort");
    check_regs("R10 partial byte abort");

    // R10: abort a read partway through its first data byte
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_word({1'b1, 2'd0, 13'd3}, 16, 1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    repeat (HALF) @(negedge clk);
    check_bit(sdio_oe, 1'b1, "R4 shared pin driven in read data phase");
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check_bit(sdio_oe | sdo_oe, 1'b0, "R10 pins released on deselect");
    check_regs("R10 registers after aborted read");

    tx_buf[0] = 8'h80; tx_buf[1] = 8'h5A;
    xfer(1'b0, 1, 0, 2, 0, "R7 enable four-wire");
    check_regs("R7 enable four-wire");
    xfer(1'b1, 1, 1, 2, 0, "R7 read on dedicated output");

    tx_buf[0] = 8'hC0; tx_buf[1] = 8'h1E;
    xfer(1'b0, 1, 0, 2, 0, "R9 order change deferred");
    check_regs("R9 order change deferred");

    tx_buf[0] = 8'hB1;
    xfer(1'b0, 0, 3, 1, 0, "R8 lsb-first write");
    check_regs("R8 lsb-first write");
    xfer(1'b1, 3, 1, 3, 0, "R8 lsb-first streaming read");

    tx_buf[0] = 8'h00;
    xfer(1'b0, 0, 0, 1, 0, "R8 R9 back to msb-first three-wire");
    check_regs("R8 R9 back to msb-first three-wire");
    xfer(1'b1, 1, 0, 2, 0, "R1 R9 msb-first three-wire read");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: unread expected bytes actual %0d, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule